// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing half of a byte-addressed serial memory. It watches already synchronised samples of the two-wire clock and data lines, picks out bus start and stop conditions, and decodes the command stream addressed to it. It then drives the memory side through a single-cycle byte port. The storage array and the write-cycle controller sit behind that port. The block drives the data line only through an open-drain enable. A high enable pulls the line low; a low enable releases it.

A transfer opens with a control byte. Bits [7:4] hold the type code 1010, bits [3:1] must equal the three strap inputs, and bit [0] selects the direction (0 = write, 1 = read). A write carries a two-byte word address, most significant bit first, of which only the low 12 bits count. Data bytes may follow it. A repeated start followed by a read control byte turns the address phase into a random read. A read with no address phase carries on from the internal pointer. While the memory reports a write cycle in progress, the block acknowledges nothing and drops back to idle.

On the memory port, a write is a one-cycle `mem_we_o` pulse carrying `mem_addr_o` and `mem_wdata_o`. A read is a one-cycle `mem_re_o` pulse carrying `mem_addr_o`, and `mem_rdata_i` must be valid on the following cycle.

Top module: `twi_mem_slave`

## Requirements
- R1: A falling data edge while the clock is high opens a transfer, and a rising data edge while the clock is high closes it. A stop in the middle of a byte returns the block to idle. Bytes clocked with no preceding start get no acknowledge and cause no memory write. After reset the data enable and both memory strobes are low.
- R2: The control byte is acknowledged only when bits [7:4] are 1010 and bits [3:1] equal the strap inputs. On a mismatch the bus stays released, and no later byte is acknowledged until the next start.
- R3: An acknowledge holds the data line low for the whole high phase of the ninth clock. The enable changes only while the clock is low, no earlier than the second sampled cycle after the clock falls, and it is released again after the ninth clock falls.
- R4: In a write, the two bytes after the control byte form the word address. The first byte carries bits [11:8] in its low nibble, and its upper nibble is ignored. The second byte carries bits [7:0]. Both bytes are acknowledged.
- R5: Each write data byte is acknowledged and issued as exactly one write strobe. The first byte goes to the loaded address, and each later byte goes to the next address.
- R6: A repeated start followed by a read control byte returns data starting at the word address loaded just before it. The master's acknowledge lets the read continue with the next address.
- R7: A read control byte with no address phase returns data from the internal pointer. The pointer is left one past the last byte written, or one past the last byte sent.
- R8: Sequential reads and multi-byte writes step through the 4096-byte space and wrap from address 0xFFF to 0x000.
- R9: After a read byte that the master does not acknowledge, the block releases the data line and drives nothing more until the next start.
- R10: While `mem_busy_i` is high when a byte completes, that byte is not acknowledged, the block returns to idle, and no write strobe is issued. This covers the block's own control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised serial clock sample |
| sda_i | input | 1 | Synchronised serial data sample |
| strap_i | input | 3 | Chip-select strap compared with control bits [3:1] |
| sda_oe_o | output | 1 | Open-drain enable, 1 pulls the data line low |
| mem_addr_o | output | 12 | Memory byte address for the current strobe |
| mem_wdata_o | output | 8 | Write data, valid with `mem_we_o` |
| mem_we_o | output | 1 | One-cycle write strobe |
| mem_re_o | output | 1 | One-cycle read strobe |
| mem_rdata_i | input | 8 | Read data, valid one cycle after `mem_re_o` |
| mem_busy_i | input | 1 | Memory write cycle in progress |

## Verification
The command decoder is driven with the following control bytes:
- the right code and strap;
- the right code with a foreign strap, and with a different strap setting;
- a foreign type code;
- a byte clocked with no start at all.

Together these separate the code check, the strap check and the start gating. Addresses are sent with a non-zero upper nibble, to show that those bits are dropped. Reads are run in three forms: after a repeated start, from the bare pointer, and across the 0xFFF boundary. These distinguish a pointer that is loaded, held, advanced and wrapped. A scoreboard of expected write strobes catches any write that should have been suppressed by busy, by a mid-byte stop or by a missing start. It also catches missing, misaddressed or extra writes.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_DEC,
    ST_ACK,
    ST_TX,
    ST_MACK
  } twi_st_e;

  typedef enum logic [1:0] {
    PH_CTRL,
    PH_AHI,
    PH_ALO,
    PH_DATA
  } twi_ph_e;

endpackage

// File: rtl/twi_cond_det.sv
module twi_cond_det (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q, fall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      fall_q <= 1'b0;
    end else begin
      scl_q  <= scl_i;
      sda_q  <= sda_i;
      fall_q <= scl_q & ~scl_i;
    end
  end

  // start/stop: data moves while clock held high across two samples
  assign start_o = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o  = scl_q & scl_i & ~sda_q & sda_i;
  assign rise_o  = ~scl_q & scl_i;
  // fall reported one cycle late so output changes sit well inside the low phase
  assign fall_o  = fall_q;
endmodule

// File: rtl/twi_addr_ptr.sv
module twi_addr_ptr #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_hi,
  input  logic          ld_lo,
  input  logic          inc,
  input  logic [7:0]    byte_i,
  output logic [AW-1:0] ptr_o
);
  localparam int HIW = AW - 8;

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (ld_hi) begin
      ptr_q[AW-1:8] <= byte_i[HIW-1:0];
    end else if (ld_lo) begin
      ptr_q[7:0] <= byte_i;
    end else if (inc) begin
      ptr_q <= ptr_q + AW'(1);  // natural wrap at top of space
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_pkg::*;
#(
  parameter int               AW        = 12,
  parameter int               SELW      = 3,
  parameter logic [6-SELW:0]  TYPE_CODE = 4'b1010
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic [SELW-1:0] strap_i,
  output logic            sda_oe_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [7:0]      mem_wdata_o,
  output logic            mem_we_o,
  output logic            mem_re_o,
  input  logic [7:0]      mem_rdata_i,
  input  logic            mem_busy_i
);
  localparam int BCW = 4;

  logic c_start, c_stop, c_rise, c_fall;
  logic [AW-1:0] ptr;
  logic ld_hi, ld_lo, inc_w, inc_r, dec_ok, ctrl_hit;

  twi_st_e        st;
  twi_ph_e        ph;
  logic [BCW-1:0] bcnt;
  logic [7:0]     sh, tx;
  logic           rw, oe, we, re, re_q, pre, mack;
  logic [7:0]     wdat;
  logic [AW-1:0]  addr;

  twi_cond_det u_cond (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .start_o(c_start),
    .stop_o (c_stop),
    .rise_o (c_rise),
    .fall_o (c_fall)
  );

  assign dec_ok   = (st == ST_DEC) && c_fall && !c_start && !c_stop && !mem_busy_i;
  assign ctrl_hit = (sh[7:SELW+1] == TYPE_CODE) && (sh[SELW:1] == strap_i);
  assign ld_hi    = dec_ok && (ph == PH_AHI);
  assign ld_lo    = dec_ok && (ph == PH_ALO);
  assign inc_w    = dec_ok && (ph == PH_DATA);
  assign inc_r    = (st == ST_TX) && c_fall && (bcnt == BCW'(8)) && !c_start && !c_stop;

  twi_addr_ptr #(.AW(AW)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .ld_hi (ld_hi),
    .ld_lo (ld_lo),
    .inc   (inc_w | inc_r),
    .byte_i(sh),
    .ptr_o (ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      ph   <= PH_CTRL;
      bcnt <= '0;
      sh   <= '0;
      tx   <= '0;
      rw   <= 1'b0;
      oe   <= 1'b0;
      we   <= 1'b0;
      re   <= 1'b0;
      re_q <= 1'b0;
      pre  <= 1'b0;
      mack <= 1'b0;
      wdat <= '0;
      addr <= '0;
    end else begin
      we   <= 1'b0;
      re   <= 1'b0;
      pre  <= 1'b0;
      re_q <= re;
      if (re_q) tx <= mem_rdata_i;
      if (pre) begin
        addr <= ptr;          // prefetch the next read byte
        re   <= 1'b1;
      end
      if (c_start) begin
        st   <= ST_RX;
        ph   <= PH_CTRL;
        bcnt <= '0;
        oe   <= 1'b0;
      end else if (c_stop) begin
        st <= ST_IDLE;
        oe <= 1'b0;
      end else begin
        unique case (st)
          ST_RX: begin
            if (c_rise) begin
              sh <= {sh[6:0], sda_i};
              if (bcnt == BCW'(7)) begin
                bcnt <= '0;
                st   <= ST_DEC;
              end else begin
                bcnt <= bcnt + BCW'(1);
              end
            end
          end
          ST_DEC: begin
            if (c_fall) begin
              if (mem_busy_i) begin
                st <= ST_IDLE;      // silent while a write cycle runs
              end else begin
                unique case (ph)
                  PH_CTRL: begin
                    if (ctrl_hit) begin
                      oe <= 1'b1;
                      st <= ST_ACK;
                      rw <= sh[0];
                      if (sh[0]) begin
                        addr <= ptr;
                        re   <= 1'b1;
                      end
                    end else begin
                      st <= ST_IDLE;
                    end
                  end
                  PH_DATA: begin
                    oe   <= 1'b1;
                    st   <= ST_ACK;
                    addr <= ptr;
                    wdat <= sh;
                    we   <= 1'b1;
                  end
                  default: begin
                    oe <= 1'b1;
                    st <= ST_ACK;
                  end
                endcase
              end
            end
          end
          ST_ACK: begin
            if (c_fall) begin
              if (ph == PH_CTRL && rw) begin
                oe   <= ~tx[7];
                tx   <= {tx[6:0], 1'b1};
                bcnt <= BCW'(1);
                st   <= ST_TX;
              end else begin
                oe   <= 1'b0;
                bcnt <= '0;
                st   <= ST_RX;
                unique case (ph)
                  PH_CTRL: ph <= PH_AHI;
                  PH_AHI:  ph <= PH_ALO;
                  default: ph <= PH_DATA;
                endcase
              end
            end
          end
          ST_TX: begin
            if (c_fall) begin
              if (bcnt == BCW'(8)) begin
                oe  <= 1'b0;
                st  <= ST_MACK;
                pre <= 1'b1;
              end else begin
                oe   <= ~tx[7];
                tx   <= {tx[6:0], 1'b1};
                bcnt <= bcnt + BCW'(1);
              end
            end
          end
          ST_MACK: begin
            if (c_rise) mack <= ~sda_i;
            if (c_fall) begin
              if (mack) begin
                oe   <= ~tx[7];
                tx   <= {tx[6:0], 1'b1};
                bcnt <= BCW'(1);
                st   <= ST_TX;
              end else begin
                st <= ST_IDLE;      // master ended the read
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe;
  assign mem_addr_o  = addr;
  assign mem_wdata_o = wdat;
  assign mem_we_o    = we;
  assign mem_re_o    = re;
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic sda_oe_o,
  input logic mem_we_o,
  input logic mem_re_o,
  input logic mem_busy_i
);
  // R3: enable moves only deep inside the clock low phase
  p_oe_scl_low_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe_o) |-> (!scl_i && !$past(scl_i)));

  // R3: enable is steady for the whole clock high phase
  p_oe_hold_high_r3: assert property (@(posedge clk) disable iff (rst)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));

  // R10: no drive starts on a byte decided while busy
  p_busy_silent_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> !$past(mem_busy_i));

  // R5: one strobe per byte
  p_we_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |=> !mem_we_o);

  // R6: read strobe is a single cycle
  p_re_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    mem_re_o |=> !mem_re_o);

  // R5: never read and write together
  p_we_re_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(mem_we_o && mem_re_o));
endmodule

bind twi_mem_slave twi_mem_slave_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_i     (scl_i),
  .sda_oe_o  (sda_oe_o),
  .mem_we_o  (mem_we_o),
  .mem_re_o  (mem_re_o),
  .mem_busy_i(mem_busy_i)
);

// File: tb/twi_mem_slave_bench.sv
module twi_mem_slave_bench;
  localparam int CLK_NS = 10;
  localparam int Q      = 4;
  localparam logic [7:0] CW = 8'hAA;  // 1010 strap 101 write
  localparam logic [7:0] CR = 8'hAB;  // 1010 strap 101 read

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_oe, we, re;
  logic [11:0] addr;
  logic [7:0] wdata, rdata;
  wire sda_line;

  int n_chk = 0, n_fail = 0;

  assign sda_line = sda_m & ~sda_oe;
  always #(CLK_NS/2) clk = ~clk;

  twi_mem_slave u_twi_mem_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .strap_i(strap),
    .sda_oe_o(sda_oe), .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_we_o(we),
    .mem_re_o(re), .mem_rdata_i(rdata), .mem_busy_i(busy)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  // memory model: unwritten cells read as pat(address)
  logic [7:0] mem [4096];
  bit         written [4096];
  always @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
      written[addr] <= 1'b1;
    end
    if (re) rdata <= written[addr] ? mem[addr] : pat(int'(addr));
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard of expected write strobes
  typedef struct { logic [11:0] a; logic [7:0] d; } wr_t;
  wr_t wq[$];

  task automatic push_wr(logic [11:0] a, logic [7:0] d);
    wr_t e;
    e.a = a; e.d = d;
    wq.push_back(e);
  endtask

  always @(negedge clk) begin
    if (!rst && we) begin
      if (wq.size() == 0) begin
        chk("R5 unexpected write", {20'h0, addr}, 32'hFFFFFFFF);
      end else begin
        wr_t e;
        e = wq.pop_front();
        chk("R5 write addr", {20'h0, addr}, {20'h0, e.a});
        chk("R5 write data", {24'h0, wdata}, {24'h0, e.d});
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop;
    tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic clk_bit(input logic b, output logic o);
    tick(Q); sda_m = b; tick(Q); scl_m = 1'b1; tick(Q); o = sda_line; tick(Q); scl_m = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    logic o;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], o);
    clk_bit(1'b1, o);
    ack = ~o;
  endtask

  task automatic wr_ack(string req, logic [7:0] b, logic exp_ack);
    logic a;
    put_byte(b, a);
    chk(req, {31'h0, a}, {31'h0, exp_ack});
  endtask

  task automatic rd_chk(string req, logic mack, logic [7:0] exp);
    logic o;
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, o);
      v[i] = o;
    end
    clk_bit(~mack, o);
    chk(req, {24'h0, v}, {24'h0, exp});
  endtask

  initial begin
    logic o;
    tick(5);
    chk("R1 reset state", {29'h0, sda_oe, we, re}, 32'h0);
    rst = 1'b0;
    tick(4);
    chk("R1 idle after reset", {29'h0, sda_oe, we, re}, 32'h0);

    // no START: clock low first, then a matching byte
    scl_m = 1'b0;
    wr_ack("R1 no start", CW, 1'b0);
    bus_stop();

    // foreign strap, then a follow-on byte
    bus_start();
    wr_ack("R2 strap mismatch", 8'hA0, 1'b0);
    wr_ack("R2 stays idle", 8'h00, 1'b0);
    bus_stop();

    // foreign type code with the right strap
    bus_start();
    wr_ack("R2 type mismatch", 8'h2A, 1'b0);
    bus_stop();

    // write three bytes at 0x340, upper address nibble garbage
    bus_start();
    wr_ack("R3 control ack", CW, 1'b1);
    tick(Q - 1);
    chk("R3 released after ack", {31'h0, sda_oe}, 32'h0);
    wr_ack("R4 addr hi", 8'hF3, 1'b1);
    wr_ack("R4 addr lo", 8'h40, 1'b1);
    push_wr(12'h340, 8'h11);
    push_wr(12'h341, 8'h22);
    push_wr(12'h342, 8'h33);
    wr_ack("R5 data0", 8'h11, 1'b1);
    wr_ack("R5 data1", 8'h22, 1'b1);
    wr_ack("R5 data2", 8'h33, 1'b1);
    bus_stop();

    // random read at 0x341 via repeated start
    bus_start();
    wr_ack("R6 ctrl w", CW, 1'b1);
    wr_ack("R6 addr hi", 8'h03, 1'b1);
    wr_ack("R6 addr lo", 8'h41, 1'b1);
    bus_start();
    wr_ack("R6 ctrl r", CR, 1'b1);
    rd_chk("R6 first byte", 1'b1, 8'h22);
    rd_chk("R9 last byte", 1'b0, 8'h33);
    rd_chk("R9 released after nack", 1'b0, 8'hFF);
    bus_stop();

    // current-address read from the pointer (0x343)
    bus_start();
    wr_ack("R7 ctrl r", CR, 1'b1);
    rd_chk("R7 pointer byte", 1'b0, pat(12'h343));
    bus_stop();

    // write across the top of the space
    bus_start();
    wr_ack("R8 ctrl w", CW, 1'b1);
    wr_ack("R8 addr hi", 8'h0F, 1'b1);
    wr_ack("R8 addr lo", 8'hFF, 1'b1);
    push_wr(12'hFFF, 8'hA5);
    push_wr(12'h000, 8'h5A);
    wr_ack("R8 data top", 8'hA5, 1'b1);
    wr_ack("R8 data wrap", 8'h5A, 1'b1);
    bus_stop();

    // sequential read across the top of the space
    bus_start();
    wr_ack("R8 ctrl w2", CW, 1'b1);
    wr_ack("R8 addr hi2", 8'h0F, 1'b1);
    wr_ack("R8 addr lo2", 8'hFE, 1'b1);
    bus_start();
    wr_ack("R8 ctrl r", CR, 1'b1);
    rd_chk("R8 read FFE", 1'b1, pat(12'hFFE));
    rd_chk("R8 read FFF", 1'b1, 8'hA5);
    rd_chk("R8 read 000", 1'b1, 8'h5A);
    rd_chk("R8 read 001", 1'b0, pat(12'h001));
    bus_stop();

    // busy: control byte ignored
    busy = 1'b1;
    bus_start();
    wr_ack("R10 busy ctrl w", CW, 1'b0);
    bus_stop();
    bus_start();
    wr_ack("R10 busy ctrl r", CR, 1'b0);
    bus_stop();
    busy = 1'b0;

    // busy rising mid-stream: no ack, no write
    bus_start();
    wr_ack("R10 ctrl before busy", CW, 1'b1);
    wr_ack("R10 addr hi before busy", 8'h01, 1'b1);
    busy = 1'b1;
    wr_ack("R10 addr lo busy", 8'h00, 1'b0);
    wr_ack("R10 data busy", 8'h77, 1'b0);
    bus_stop();
    busy = 1'b0;

    // stop in mid-byte, then a byte with no start
    bus_start();
    wr_ack("R1 ctrl before stop", CW, 1'b1);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, o);
    bus_stop();
    scl_m = 1'b0;
    wr_ack("R1 after mid-byte stop", 8'h12, 1'b0);
    bus_stop();

    // different strap setting
    strap = 3'b010;
    bus_start();
    wr_ack("R2 new strap", 8'hA4, 1'b1);
    bus_stop();

    tick(20);
    chk("R5 all writes seen", wq.size(), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule